// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits beside a group of three timer counters. It keeps, for every counter, a choice of count source and a choice of gate source. It turns the chosen sources into a single-cycle count enable and a gate level for that counter. All reference rates are enables on the one system clock, which stands for the 10 MHz base. A decade divider chain creates 1 MHz, 100 kHz, 10 kHz and 1 kHz pulses from that base. The external clock and gate pins are brought into the clock domain through two-flop synchronizers. Their rising edges are detected in registers.

Counters can be cascaded. A channel can count on rising edges of the output of the channel before it. A channel can also take its gate from the inverted output of the channel two places back. Channel indices wrap modulo three. A typical pacer runs channel 2 from the base rate with its gate held high. Channel 0 then counts the output edges of channel 2 and also has its gate high. Software programs a selection with a byte write. The byte holds a channel field and a source code, and separate strobes choose the clock table or the gate table. The counters themselves are outside the block. Their outputs come back in as inputs.

Top module: `ctr_route_top`

## Requirements
- R1: During reset and after it, every channel selects clock code 0 and gate code 0. Its count enable therefore follows the synchronized clock pin of that channel, and its gate is high.
- R2: A write byte carries the channel in bits 4:3 and the source code in bits 2:0. Bits 7:5 are ignored. A write with `wr_clk_i` high updates the clock selection, and a write with `wr_gate_i` high updates the gate selection. Both strobes may be used in the same cycle. The new selection steers the outputs in the cycle right after the write edge.
- R3: A write whose channel field is 3 changes no selection.
- R4: Clock code 1 (base rate) holds the count enable high on every cycle.
- R5: Clock codes 2, 3, 4 and 5 give a one-cycle enable once every 10, 100, 1000 and 10000 cycles. The enable is high in the cycle after edge k, where k counts the edges since reset release and k is a multiple of the period. A pulse of a slower stage always coincides with a pulse of every faster stage.
- R6: Clock code 0 (the channel's own clock pin) and code 7 (the shared external clock) give a one-cycle enable for each rising edge of that pin. The enable is high in the cycle after the second clock edge that samples the pin high.
- R7: Clock code 6 gives a one-cycle enable for each rising edge of the output of channel (n+2) mod 3. The enable is high in the cycle after the edge that first samples that output high.
- R8: Gate code 0 drives the gate high. Code 1 and the unused codes 4 to 7 drive it low.
- R9: Gate code 2 passes the channel's gate pin through two synchronizer flops.
- R10: Gate code 3 drives the inverse of the output of channel (n+1) mod 3, as sampled at the most recent edge.
- R11: In the pacer arrangement (channel 2 on code 1 with gate code 0, channel 0 on code 6 with gate code 0), channel 0 receives exactly one enable for every rising edge of the output of channel 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, standing for the 10 MHz base |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_clk_i | input | 1 | Write strobe for the clock-source table |
| wr_gate_i | input | 1 | Write strobe for the gate-source table |
| wr_data_i | input | 8 | Configuration byte: channel in 4:3, code in 2:0 |
| clk_pin_i | input | 3 | Per-channel clock pins, asynchronous |
| ext_clk_i | input | 1 | Shared external clock, asynchronous |
| gate_pin_i | input | 3 | Per-channel gate pins, asynchronous |
| ctr_out_i | input | 3 | Outputs of the three counters |
| cnt_en_o | output | 3 | Per-channel single-cycle count enable |
| gate_o | output | 3 | Per-channel gate level |

## Verification
A selection written at edge k steers the outputs from the cycle after edge k. A decade enable is due in the cycle after edge k, where k is a multiple of its period. A pin rise sampled at edge k gives an enable after edge k+1. A gate pin level sampled at edge k reaches the gate after edge k+1. A counter output sampled at edge k gives a chained enable, and updates an inverted gate, after edge k. The bench keeps its own edge count and its own histories of pins and outputs. It works out the expected enables and gates from those after every edge. It compares them with the ports at the falling edge, when inputs driven just after the rising edge have settled.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

    localparam int CODE_W     = 3;
    localparam int CH_LSB     = 3;
    localparam int CH_W       = 2;
    localparam int DEC_STAGES = 4;
    localparam int DEC_RATIO  = 10;

    typedef enum logic [CODE_W-1:0] {
        CS_PIN   = 3'd0,
        CS_BASE  = 3'd1,
        CS_DIV1  = 3'd2,
        CS_DIV2  = 3'd3,
        CS_DIV3  = 3'd4,
        CS_DIV4  = 3'd5,
        CS_CHAIN = 3'd6,
        CS_EXT   = 3'd7
    } clk_src_e;

    typedef enum logic [CODE_W-1:0] {
        GS_HIGH  = 3'd0,
        GS_LOW   = 3'd1,
        GS_PIN   = 3'd2,
        GS_BACK2 = 3'd3
    } gate_src_e;

endpackage

// File: rtl/ctr_route_sync.sv
module ctr_route_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.s2;

endmodule

// File: rtl/ctr_route_decade.sv
module ctr_route_decade #(
    parameter int STAGES = 4,
    parameter int RATIO  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] tick_o
);

    localparam int CW = $clog2(RATIO);

    typedef struct packed {
        logic [STAGES-1:0][CW-1:0] cnt;
        logic [STAGES-1:0]         tick;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        logic carry;
        logic wrap;
        st_d  = st_q;
        carry = 1'b1;
        for (int j = 0; j < STAGES; j++) begin
            wrap = (st_q.cnt[j] == CW'(RATIO - 1));
            if (carry) st_d.cnt[j] = wrap ? '0 : st_q.cnt[j] + 1'b1;
            st_d.tick[j] = carry & wrap;
            carry        = carry & wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/ctr_route_top.sv
module ctr_route_top
    import ctr_route_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_clk_i,
    input  logic            wr_gate_i,
    input  logic [7:0]      wr_data_i,
    input  logic [N_CH-1:0] clk_pin_i,
    input  logic            ext_clk_i,
    input  logic [N_CH-1:0] gate_pin_i,
    input  logic [N_CH-1:0] ctr_out_i,
    output logic [N_CH-1:0] cnt_en_o,
    output logic [N_CH-1:0] gate_o
);

    localparam int CLK_SYNC_W = N_CH + 1;

    typedef struct packed {
        logic [N_CH-1:0][CODE_W-1:0] clk_sel;
        logic [N_CH-1:0][CODE_W-1:0] gate_sel;
        logic [CLK_SYNC_W-1:0]       pin_prev;
        logic [N_CH-1:0]             out_prev;
        logic [N_CH-1:0]             chain;
    } route_t;

    route_t st_d, st_q;

    logic [CLK_SYNC_W-1:0]       clk_lvl;
    logic [CLK_SYNC_W-1:0]       clk_rise;
    logic [N_CH-1:0]             gate_lvl;
    logic [DEC_STAGES-1:0]       tick;
    logic [N_CH-1:0][CODE_W-1:0] clk_sel_q;
    logic [N_CH-1:0][CODE_W-1:0] gate_sel_q;
    logic [N_CH-1:0]             chain_q;
    logic [CH_W-1:0]             wr_ch;
    logic [CODE_W-1:0]           wr_code;
    logic                        unused_upper;

    ctr_route_sync #(.W(CLK_SYNC_W)) i_clk_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ext_clk_i, clk_pin_i}),
        .lvl_o (clk_lvl)
    );

    ctr_route_sync #(.W(N_CH)) i_gate_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (gate_pin_i),
        .lvl_o (gate_lvl)
    );

    ctr_route_decade #(.STAGES(DEC_STAGES), .RATIO(DEC_RATIO)) i_decade (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    assign wr_ch        = wr_data_i[CH_LSB +: CH_W];
    assign wr_code      = wr_data_i[CODE_W-1:0];
    assign unused_upper = ^wr_data_i[7:CH_LSB+CH_W];

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < N_CH; c++) begin
            if (wr_clk_i  && wr_ch == CH_W'(c)) st_d.clk_sel[c]  = wr_code;
            if (wr_gate_i && wr_ch == CH_W'(c)) st_d.gate_sel[c] = wr_code;
        end
        st_d.pin_prev = clk_lvl;
        st_d.out_prev = ctr_out_i;
        st_d.chain    = ctr_out_i & ~st_q.out_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_rise   = clk_lvl & ~st_q.pin_prev;
    assign clk_sel_q  = st_q.clk_sel;
    assign gate_sel_q = st_q.gate_sel;
    assign chain_q    = st_q.chain;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int PREV  = (c + N_CH - 1) % N_CH;
        localparam int BACK2 = (c + N_CH - 2) % N_CH;

        always_comb begin
            case (clk_src_e'(clk_sel_q[c]))
                CS_PIN:   cnt_en_o[c] = clk_rise[c];
                CS_BASE:  cnt_en_o[c] = 1'b1;
                CS_DIV1:  cnt_en_o[c] = tick[0];
                CS_DIV2:  cnt_en_o[c] = tick[1];
                CS_DIV3:  cnt_en_o[c] = tick[2];
                CS_DIV4:  cnt_en_o[c] = tick[3];
                CS_CHAIN: cnt_en_o[c] = chain_q[PREV];
                default:  cnt_en_o[c] = clk_rise[N_CH];
            endcase
        end

        always_comb begin
            case (gate_sel_q[c])
                GS_HIGH:  gate_o[c] = 1'b1;
                GS_PIN:   gate_o[c] = gate_lvl[c];
                GS_BACK2: gate_o[c] = ~st_q.out_prev[BACK2];
                default:  gate_o[c] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk
    import ctr_route_pkg::*;
#(
    parameter int N_CH = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_clk_i,
    input logic                        wr_gate_i,
    input logic [7:0]                  wr_data_i,
    input logic [N_CH-1:0][CODE_W-1:0] clk_sel_q,
    input logic [N_CH-1:0][CODE_W-1:0] gate_sel_q,
    input logic [DEC_STAGES-1:0]       tick,
    input logic [N_CH-1:0]             chain_q
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        AST_CLK_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clk_i && wr_data_i[CH_LSB +: CH_W] == CH_W'(c))
            |=> clk_sel_q[c] == $past(wr_data_i[CODE_W-1:0])); // R2
        AST_GATE_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_gate_i && wr_data_i[CH_LSB +: CH_W] == CH_W'(c))
            |=> gate_sel_q[c] == $past(wr_data_i[CODE_W-1:0])); // R2
        AST_CHAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            chain_q[c] |=> !chain_q[c]); // R7
    end

    AST_BAD_CH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_clk_i || wr_gate_i) && wr_data_i[CH_LSB +: CH_W] >= CH_W'(N_CH))
        |=> ($stable(clk_sel_q) && $stable(gate_sel_q))); // R3

    for (genvar j = 0; j < DEC_STAGES; j++) begin : g_dec
        AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            tick[j] |=> !tick[j]); // R5
        if (j > 0) begin : g_nest
            AST_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
                tick[j] |-> tick[j-1]); // R5
        end
    end

endmodule

bind ctr_route_top ctr_route_chk #(.N_CH(N_CH)) i_ctr_route_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_clk_i   (wr_clk_i),
    .wr_gate_i  (wr_gate_i),
    .wr_data_i  (wr_data_i),
    .clk_sel_q  (clk_sel_q),
    .gate_sel_q (gate_sel_q),
    .tick       (tick),
    .chain_q    (chain_q)
);

// File: tb/test_ctr_route_top.sv
module test_ctr_route_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_clk_i, wr_gate_i;
    logic [7:0] wr_data_i;
    logic [2:0] clk_pin_i, gate_pin_i, ctr_out_i;
    logic       ext_clk_i;
    logic [2:0] cnt_en_o, gate_o;

    int checks = 0;
    int errors = 0;
    bit rand_pins = 0;
    bit rand_outs = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    ctr_route_top i_ctr_route_top (
        .clk(clk), .rst_n(rst_n), .wr_clk_i(wr_clk_i), .wr_gate_i(wr_gate_i),
        .wr_data_i(wr_data_i), .clk_pin_i(clk_pin_i), .ext_clk_i(ext_clk_i),
        .gate_pin_i(gate_pin_i), .ctr_out_i(ctr_out_i),
        .cnt_en_o(cnt_en_o), .gate_o(gate_o)
    );

    // behavioural reference: edge count, selection tables, input histories
    int       k;
    bit [2:0] m_csel [3];
    bit [2:0] m_gsel [3];
    bit [3:0] pin_h0, pin_h1, pin_h2;   // {ext, clk pins} at edges k, k-1, k-2
    bit [2:0] gp_h0, gp_h1;
    bit [2:0] out_h0, out_h1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k = 0;
            for (int i = 0; i < 3; i++) begin m_csel[i] = 0; m_gsel[i] = 0; end
            pin_h0 = 0; pin_h1 = 0; pin_h2 = 0;
            gp_h0 = 0; gp_h1 = 0; out_h0 = 0; out_h1 = 0;
        end else begin
            k++;
            pin_h2 = pin_h1; pin_h1 = pin_h0; pin_h0 = {ext_clk_i, clk_pin_i};
            gp_h1 = gp_h0; gp_h0 = gate_pin_i;
            out_h1 = out_h0; out_h0 = ctr_out_i;
            if (wr_clk_i && wr_data_i[4:3] < 3) m_csel[wr_data_i[4:3]] = wr_data_i[2:0];
            if (wr_gate_i && wr_data_i[4:3] < 3) m_gsel[wr_data_i[4:3]] = wr_data_i[2:0];
        end
    end

    function automatic bit exp_en(int i);
        int per;
        case (m_csel[i])
            0: return pin_h1[i] & ~pin_h2[i];
            1: return 1'b1;
            6: return out_h0[(i + 2) % 3] & ~out_h1[(i + 2) % 3];
            7: return pin_h1[3] & ~pin_h2[3];
            default: begin
                per = 10 ** (int'(m_csel[i]) - 1);
                return (k > 0) && (k % per == 0);
            end
        endcase
    endfunction

    function automatic bit exp_gate(int i);
        case (m_gsel[i])
            0: return 1'b1;
            2: return gp_h1[i];
            3: return ~out_h0[(i + 1) % 3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string clk_req(bit [2:0] c);
        case (c)
            0, 7: return "R6";
            1: return "R4";
            6: return "R7";
            default: return "R5";
        endcase
    endfunction

    function automatic string gate_req(bit [2:0] c);
        case (c)
            2: return "R9";
            3: return "R10";
            default: return "R8";
        endcase
    endfunction

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 3; i++) begin
                checks++;
                if (cnt_en_o[i] !== exp_en(i)) begin
                    errors++;
                    $display("FAIL %s/%s k=%0d ch%0d cnt_en actual=%b expected=%b",
                             clk_req(m_csel[i]), tag, k, i, cnt_en_o[i], exp_en(i));
                end
                checks++;
                if (gate_o[i] !== exp_gate(i)) begin
                    errors++;
                    $display("FAIL %s/%s k=%0d ch%0d gate actual=%b expected=%b",
                             gate_req(m_gsel[i]), tag, k, i, gate_o[i], exp_gate(i));
                end
            end
        end
    end

    task automatic step(int n);
        for (int s = 0; s < n; s++) begin
            @(posedge clk); #5;
            wr_clk_i = 0; wr_gate_i = 0;
            if (rand_pins) begin
                clk_pin_i  = 3'($urandom);
                ext_clk_i  = 1'($urandom);
                gate_pin_i = 3'($urandom);
            end
            if (rand_outs) ctr_out_i = 3'($urandom);
        end
    endtask

    task automatic wr(bit is_gate, bit [7:0] data);
        @(posedge clk); #5;
        wr_clk_i = !is_gate; wr_gate_i = is_gate; wr_data_i = data;
        @(posedge clk); #5;
        wr_clk_i = 0; wr_gate_i = 0;
    endtask

    function automatic bit [7:0] cfg(int ch, int code);
        return {3'b000, 2'(ch), 3'(code)};
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired k=%0d actual=running expected=finished", k);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rises, ens, div;
        rst_n = 0; wr_clk_i = 0; wr_gate_i = 0; wr_data_i = 0;
        clk_pin_i = 0; ext_clk_i = 0; gate_pin_i = 0; ctr_out_i = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;   // R1 reset state
        if (cnt_en_o !== 3'b000 || gate_o !== 3'b111) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b/%b expected=000/111", cnt_en_o, gate_o);
        end
        #5 rst_n = 1;

        tag = "R1"; rand_pins = 1; step(60);

        tag = "R2";
        wr(0, cfg(0, 1)); wr(0, cfg(1, 2)); wr(0, cfg(2, 3));
        step(250);
        // both strobes at once, upper bits set (ignored)
        @(posedge clk); #5;
        wr_clk_i = 1; wr_gate_i = 1; wr_data_i = 8'b101_00_001;
        step(5);

        tag = "R5";
        wr(0, cfg(0, 4)); wr(0, cfg(1, 5)); wr(0, cfg(2, 7));
        step(10200);

        tag = "R3";
        wr(0, 8'b000_11_001); wr(1, 8'b000_11_001); step(10);
        wr(0, 8'b111_00_110); step(10);

        tag = "R9"; rand_outs = 1;
        wr(1, cfg(0, 1)); wr(1, cfg(1, 2)); wr(1, cfg(2, 3));
        step(200);
        wr(1, cfg(0, 5)); wr(1, cfg(1, 3)); wr(1, cfg(2, 0));
        step(100);

        tag = "R7";
        wr(0, cfg(0, 6)); wr(0, cfg(1, 6)); wr(0, cfg(2, 6));
        step(200);

        // pacer cascade
        tag = "R11"; rand_outs = 0; rand_pins = 0; ctr_out_i = 0;
        wr(0, cfg(2, 1)); wr(1, cfg(2, 0));
        wr(0, cfg(0, 6)); wr(1, cfg(0, 0));
        step(4);
        rises = 0; ens = 0; div = 0;
        for (int s = 0; s < 400; s++) begin
            @(negedge clk);
            if (cnt_en_o[0]) ens++;
            @(posedge clk); #5;
            if (s < 390) begin
                div = (div + 1) % 5;
                if (div == 0 && !ctr_out_i[2]) rises++;
                ctr_out_i[2] = (div == 0);
            end
        end
        checks++;
        if (ens != rises) begin
            errors++;
            $display("FAIL R11 pacer enables actual=%0d expected=%0d", ens, rises);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule